// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block turns a 12-bit packed operand field into the second ALU operand and a shifter carry. The register file has already read two values: the source value named by field bits 3:0, and an amount value named by bits 11:8. The block applies a logical-left, logical-right, arithmetic-right or rotate-right shift to the source value. The shift amount is either a 5-bit constant held in the field or the low byte of the amount value. Alongside the result it produces the carry-out that the flag logic will latch. Reading the register file, storing flags, the ALU itself and rotated-constant operands are left to neighbouring blocks.

The unit is purely combinational. A decode stage first rewrites the encodings that carry a special meaning into a plain operation with an explicit amount and a bypass flag. A zero constant means 32 for the right shifts, a zero constant in the rotate form means a one-bit rotate through carry, and a zero register amount means no shift. The datapath stage then applies one of five shift kinds.

Top module: `shop_unit`

## Requirements
- R1: Field bits 6:5 select the shift type (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). Bit 4 = 1 takes the amount from bits 7:0 of `rs_val`, and bit 4 = 0 takes it from the 5-bit constant in bits 11:7. Bit 7 has no effect in the register-amount form.
- R2: Logical left by a constant n of 1..31 gives `rm_val << n` with carry `rm_val[32-n]`. A constant of 0 passes `rm_val` and `carry_in` through unchanged.
- R3: Logical right by a constant n of 1..31 gives `rm_val >> n` with carry `rm_val[n-1]`. A constant of 0 means a shift of 32, which gives a zero result and carry `rm_val[31]`.
- R4: Arithmetic right by a constant n of 1..31 fills the vacated upper bits with `rm_val[31]`, with carry `rm_val[n-1]`. A constant of 0 gives 32 copies of `rm_val[31]` and carry `rm_val[31]`.
- R5: Rotate right by a constant n of 1..31 gives the source rotated by n, with carry `rm_val[n-1]`.
- R6: Rotate right with a constant of 0 gives `{carry_in, rm_val[31:1]}` with carry `rm_val[0]`.
- R7: In the register-amount form, if `rs_val[7:0]` is 0 the result equals `rm_val` and the carry equals `carry_in` for every shift type. Bits 31:8 of `rs_val` are ignored.
- R8: For logical shifts with a register amount, an amount of 1..31 behaves as in R2/R3. An amount of 32 gives a zero result with carry `rm_val[0]` (left) or `rm_val[31]` (right). Amounts of 33..255 give a zero result and carry 0.
- R9: Arithmetic right with a register amount of 32..255 gives 32 copies of `rm_val[31]` and carry `rm_val[31]`. Amounts of 1..31 behave as in R4.
- R10: Rotate right with a nonzero register amount rotates by its low 5 bits, with carry equal to the last bit rotated out. If those 5 bits are 0, the result is `rm_val` and the carry is `rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field | input | 12 | Packed operand field: type, amount source and constant amount |
| rm_val | input | 32 | Value to be shifted |
| rs_val | input | 32 | Value holding a register-specified amount (low byte used) |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Every constant amount from 0 to 31 is applied to each of the four shift types. This separates the zero-constant reinterpretations (bypass, shift of 32, rotate through carry) from ordinary shifts. Register amounts are taken at 0, 1, 7, 31, 32, 33, 64, 200, 255 and a value with only upper bits set. These values separate bypass from flush, sign saturation and rotation by the low 5 bits, and they show that the upper bits of the amount value are ignored. The source patterns use a set sign bit, a set low bit and alternating bits, so a carry taken from the wrong bit position or a fill of the wrong polarity shows up. Both values of `carry_in` are used, so the carry is seen either passing through or being replaced.

// File: rtl/shop_pkg.sv
package shop_pkg;

  localparam int XLEN  = 32;
  localparam int AMT_W = 8;
  localparam int ROT_W = $clog2(XLEN);

  typedef enum logic [2:0] {
    SK_LSL,
    SK_LSR,
    SK_ASR,
    SK_ROR,
    SK_RRX
  } shift_kind_e;

  // Result in [XLEN-1:0], carry in [XLEN]. Amounts past XLEN flush to zero.
  function automatic logic [XLEN:0] f_lsl(input logic [XLEN-1:0] v,
                                          input logic [AMT_W-1:0] n);
    logic [2*XLEN:0] ext;
    ext = {{(XLEN+1){1'b0}}, v} << n;
    return {ext[XLEN], ext[XLEN-1:0]};
  endfunction

  function automatic logic [XLEN:0] f_lsr(input logic [XLEN-1:0] v,
                                          input logic [AMT_W-1:0] n);
    logic [XLEN:0] ext;
    ext = {v, 1'b0} >> n;
    return {ext[0], ext[XLEN:1]};
  endfunction

  function automatic logic [XLEN:0] f_asr(input logic [XLEN-1:0] v,
                                          input logic [AMT_W-1:0] n);
    logic signed [XLEN:0] ext;
    logic [AMT_W-1:0]     m;
    m   = (n > AMT_W'(XLEN)) ? AMT_W'(XLEN) : n;
    ext = {v, 1'b0};
    ext = ext >>> m;
    return {ext[0], ext[XLEN:1]};
  endfunction

  // The last bit rotated out always lands in the result's top bit.
  function automatic logic [XLEN:0] f_ror(input logic [XLEN-1:0] v,
                                          input logic [AMT_W-1:0] n);
    logic [ROT_W-1:0] r;
    logic [XLEN-1:0]  res;
    r   = n[ROT_W-1:0];
    res = (v >> r) | (v << (XLEN - int'(r)));
    return {res[XLEN-1], res};
  endfunction

  function automatic logic [XLEN:0] f_rrx(input logic [XLEN-1:0] v,
                                          input logic cin);
    return {v[0], cin, v[XLEN-1:1]};
  endfunction

endpackage

// File: rtl/shop_decode.sv
module shop_decode
  import shop_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input  logic [FIELD_W-1:0] op_field,
  input  logic [XLEN-1:0]    amt_src,
  output shift_kind_e        kind,
  output logic [AMT_W-1:0]   amount,
  output logic               bypass,
  output logic               reg_form
);

  localparam int IMM_LO = 7;
  localparam int IMM_W  = FIELD_W - IMM_LO;

  logic [1:0]       type_bits;
  logic [IMM_W-1:0] imm_amt;

  assign type_bits = op_field[6:5];
  assign imm_amt   = op_field[FIELD_W-1:IMM_LO];
  assign reg_form  = op_field[4];

  always_comb begin
    bypass = 1'b0;
    case (type_bits)
      2'b00:   kind = SK_LSL;
      2'b01:   kind = SK_LSR;
      2'b10:   kind = SK_ASR;
      default: kind = SK_ROR;
    endcase
    if (reg_form) begin
      amount = amt_src[AMT_W-1:0];
      bypass = (amount == '0);
    end else begin
      amount = AMT_W'(imm_amt);
      if (imm_amt == '0) begin
        case (type_bits)
          2'b00:   bypass = 1'b1;
          2'b01,
          2'b10:   amount = AMT_W'(XLEN);
          default: kind   = SK_RRX;
        endcase
      end
    end
  end

endmodule

// File: rtl/shop_core.sv
module shop_core
  import shop_pkg::*;
(
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amount,
  input  logic             bypass,
  input  logic [XLEN-1:0]  src,
  input  logic             cin,
  output logic [XLEN-1:0]  res,
  output logic             cout
);

  logic [XLEN:0] packed_out;

  always_comb begin
    if (bypass) begin
      packed_out = {cin, src};
    end else begin
      case (kind)
        SK_LSL:  packed_out = f_lsl(src, amount);
        SK_LSR:  packed_out = f_lsr(src, amount);
        SK_ASR:  packed_out = f_asr(src, amount);
        SK_ROR:  packed_out = f_ror(src, amount);
        default: packed_out = f_rrx(src, cin);
      endcase
    end
  end

  assign res  = packed_out[XLEN-1:0];
  assign cout = packed_out[XLEN];

endmodule

// File: rtl/shop_unit.sv
module shop_unit
  import shop_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input  logic [FIELD_W-1:0] op_field,
  input  logic [XLEN-1:0]    rm_val,
  input  logic [XLEN-1:0]    rs_val,
  input  logic               carry_in,
  output logic [XLEN-1:0]    result,
  output logic               carry_out
);

  shift_kind_e      kind;
  logic [AMT_W-1:0] amount;
  logic             pass_thru;
  logic             reg_form;

  // Named events for the checker
  logic rrx_sel;
  logic amt_big;

  assign rrx_sel = (kind == SK_RRX);
  assign amt_big = (amount >= AMT_W'(XLEN));

  shop_decode #(.FIELD_W(FIELD_W)) u_decode (
    .op_field (op_field),
    .amt_src  (rs_val),
    .kind     (kind),
    .amount   (amount),
    .bypass   (pass_thru),
    .reg_form (reg_form)
  );

  shop_core u_core (
    .kind   (kind),
    .amount (amount),
    .bypass (pass_thru),
    .src    (rm_val),
    .cin    (carry_in),
    .res    (result),
    .cout   (carry_out)
  );

endmodule

// File: rtl/shop_unit_chk.sv
module shop_unit_chk
  import shop_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input logic [FIELD_W-1:0] op_field,
  input logic [XLEN-1:0]    rm_val,
  input logic               carry_in,
  input logic [XLEN-1:0]    result,
  input logic               carry_out,
  input logic               pass_thru,
  input logic               rrx_sel,
  input logic               amt_big
);

  always_comb begin
    // R7
    pass_thru_chk: assert (!pass_thru ||
                           (result == rm_val && carry_out == carry_in));
    // R6
    rrx_fill_chk: assert (!rrx_sel ||
                          (result[XLEN-1] == carry_in && carry_out == rm_val[0]));
    // R10
    ror_carry_chk: assert (!(op_field[6:5] == 2'b11 && !rrx_sel && !pass_thru) ||
                           carry_out == result[XLEN-1]);
    // R9
    asr_sat_chk: assert (!(op_field[6:5] == 2'b10 && amt_big && !pass_thru) ||
                         ((result == {XLEN{rm_val[XLEN-1]}}) &&
                          carry_out == rm_val[XLEN-1]));
    // R8
    logic_flush_chk: assert (!(!op_field[6] && amt_big && !pass_thru) ||
                             result == '0);
  end

endmodule

bind shop_unit shop_unit_chk #(.FIELD_W(FIELD_W)) u_chk (
  .op_field  (op_field),
  .rm_val    (rm_val),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out),
  .pass_thru (pass_thru),
  .rrx_sel   (rrx_sel),
  .amt_big   (amt_big)
);

// File: tb/shop_unit_tb.sv
module shop_unit_tb;

  localparam int W       = 32;
  localparam int NVEC    = 8;
  localparam int VEC_W   = 12 + W + W + 1 + W + 1;
  localparam int WD_CYC  = 200000;

  // {field, rm, rs, cin, exp_result, exp_carry}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {12'h200, 32'h8000_0001, 32'h0, 1'b0, 32'h0000_0010, 1'b0},  // R2 lsl #4
    {12'h0A0, 32'h8000_0001, 32'h0, 1'b0, 32'h4000_0000, 1'b1},  // R3 lsr #1
    {12'h040, 32'h8000_0001, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1},  // R4 asr #0 = 32
    {12'h060, 32'h8000_0001, 32'h0, 1'b0, 32'h4000_0000, 1'b1},  // R6 rrx
    {12'h260, 32'h8000_0001, 32'h0, 1'b0, 32'h1800_0000, 1'b0},  // R5 ror #4
    {12'h030, 32'h8000_0001, 32'h0000_0100, 1'b1, 32'h8000_0001, 1'b1},  // R7
    {12'h010, 32'hFFFF_FFFF, 32'h21, 1'b1, 32'h0, 1'b0},          // R8 lsl 33
    {12'h000, 32'h8000_0001, 32'h0, 1'b1, 32'h8000_0001, 1'b1}    // R2 lsl #0
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  op_field;
  logic [W-1:0] rm_val, rs_val, result;
  logic         carry_in, carry_out;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shop_unit u_dut (
    .op_field  (op_field),
    .rm_val    (rm_val),
    .rs_val    (rs_val),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
  );

  // Bit-serial reference: one step per shifted position.
  function automatic logic [W:0] ref_model(input logic [11:0] f, input logic [W-1:0] rm,
                                           input logic [W-1:0] rs, input logic cin);
    logic [W-1:0] r;
    logic         c;
    int           n;
    logic [1:0]   t;
    t = f[6:5];
    r = rm;
    c = cin;
    if (f[4]) n = int'(rs[7:0]);
    else begin
      n = int'(f[11:7]);
      if (n == 0 && (t == 2'b01 || t == 2'b10)) n = 32;
      if (n == 0 && t == 2'b11) return {rm[0], cin, rm[W-1:1]};
    end
    for (int i = 0; i < n; i++) begin
      case (t)
        2'b00: begin c = r[W-1]; r = {r[W-2:0], 1'b0}; end
        2'b01: begin c = r[0];   r = {1'b0, r[W-1:1]}; end
        2'b10: begin c = r[0];   r = {r[W-1], r[W-1:1]}; end
        default: begin c = r[0]; r = {r[0], r[W-1:1]}; end
      endcase
    end
    return {c, r};
  endfunction

  function automatic string req_tag(input logic [11:0] f, input logic [W-1:0] rs);
    if (f[4]) begin
      if (rs[7:0] == 8'd0) return "R7";
      case (f[6:5])
        2'b10:   return "R9";
        2'b11:   return "R10";
        default: return "R8";
      endcase
    end
    case (f[6:5])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return (f[11:7] == 5'd0) ? "R6" : "R5";
    endcase
  endfunction

  task automatic apply(input logic [11:0] f, input logic [W-1:0] rm,
                       input logic [W-1:0] rs, input logic cin);
    @(posedge clk);
    op_field = f; rm_val = rm; rs_val = rs; carry_in = cin;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] er, input logic ec);
    n_run++;
    if (result !== er || carry_out !== ec) begin
      n_fail++;
      $display("FAIL %s field=%h rm=%h rs=%h cin=%b: got %h/%b expected %h/%b",
               tag, op_field, rm_val, rs_val, carry_in, result, carry_out, er, ec);
    end
  endtask

  task automatic run_model(input logic [11:0] f, input logic [W-1:0] rm,
                           input logic [W-1:0] rs, input logic cin);
    logic [W:0] e;
    apply(f, rm, rs, cin);
    e = ref_model(f, rm, rs, cin);
    check(req_tag(f, rs), e[W-1:0], e[W]);
  endtask

  initial begin
    logic [W-1:0] pats [3];
    logic [W-1:0] amts [10];
    pats = '{32'h8000_0001, 32'hA5A5_5A5A, 32'h7FFF_FFFE};
    amts = '{32'd0, 32'd1, 32'd7, 32'd31, 32'd32, 32'd33, 32'd64, 32'd200,
             32'd255, 32'hFFFF_FF00};
    op_field = '0; rm_val = '0; rs_val = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: all-zero field is logical left by 0 of zero (R2)
    check("R2", 32'h0, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [VEC_W-1:0] x;
      x = VEC[v];
      apply(x[109:98], x[97:66], x[65:34], x[33]);
      check(req_tag(x[109:98], x[65:34]), x[32:1], x[0]);
    end

    // Constant amounts, every value, every type (R1..R6)
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 3; p++)
          run_model({a[4:0], t[1:0], 1'b0, 4'h3}, pats[p], 32'h0, p[0]);

    // Register amounts (R7..R10), including upper-bits-only value
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 10; a++)
        for (int p = 0; p < 3; p++)
          run_model({4'h2, 1'b0, t[1:0], 1'b1, 4'h3}, pats[p], amts[a], ~p[0]);

    // R1: bit 7 ignored in register form
    apply(12'h0B0, 32'h8000_0001, 32'd3, 1'b0);
    check("R1", 32'h1000_0000, 1'b0);
    // R10: rotate by 32 keeps value, carry = top bit
    apply(12'h070, 32'h8000_0001, 32'd32, 1'b0);
    check("R10", 32'h8000_0001, 1'b1);
    // R8: left by register 32, carry from bit 0
    apply(12'h010, 32'h0000_0001, 32'd32, 1'b0);
    check("R8", 32'h0, 1'b1);
    // R9: arithmetic right by 100 of a positive value
    apply(12'h050, 32'h7FFF_FFFF, 32'd100, 1'b1);
    check("R9", 32'h0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule